// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one array write into a page-sized buffer and, once the host ends the transfer cleanly, commits them to a RAM port and then holds a busy flag for a fixed number of clock cycles. The command decoder upstream supplies three things. The first is the start address, taken when the address phase of a write command completes. The second is the received data bytes, one per completed byte. The third is a chip-select-rise event, with a flag that says whether the rise came right after the last bit of a data byte. A permission lookup outside the block answers, for the address the next byte would land on, whether that address may be written.

Bytes land at successive offsets inside one aligned page. The in-page offset wraps, so a long burst overwrites the bytes it wrote earlier. A commit starts only on a clean byte-boundary chip-select rise that follows at least one data byte; any other rise throws the collected bytes away. The commit writes the buffered bytes to the RAM port in ascending offset order. The busy flag stays high for `COMMIT_CYCLES` cycles, and a one-cycle pulse then tells the status logic to clear its write enable latch. While busy, new writes, array reads and data bytes are refused. Status reads are handled elsewhere and keep running.

The data byte input is a valid/ready stream. `in_ready` is high only while a write is collecting bytes, and no other condition stalls it. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. A byte offered while `in_ready` is low is not taken, and the upstream side must either hold it or drop it. `COMMIT_CYCLES` must be at least `PAGE_BYTES`, and `PAGE_BYTES` must be a power of two.

Top module: `pwb_commit`

## Requirements
- R1: After reset, `busy`, `in_ready`, `mem_we` and `wel_clear` are all low.
- R2: A `start_valid` pulse while not busy opens a collection for the page that holds `start_addr`. From then on `in_ready` stays high until the next chip-select rise, and each cycle with `in_valid` high takes one byte.
- R3: The first byte goes to the offset of `start_addr` (its low log2(`PAGE_BYTES`) bits). Each later byte goes to the next offset, which wraps from `PAGE_BYTES`-1 to 0 in the same page, and a byte written to an offset replaces the earlier byte there.
- R4: A commit starts only when `cs_rise` arrives together with `cs_on_boundary` high and at least one byte has been taken. Any other `cs_rise` during collection ends the collection with no RAM write, no busy and no `wel_clear`.
- R5: During a commit, `mem_we` is high only while `busy` is high. It carries each buffered offset once, in ascending offset order, on `mem_addr` = {page, offset}, with the last byte taken for that offset on `mem_wdata`, and all of these writes finish within the first `PAGE_BYTES` busy cycles.
- R6: `perm_addr` shows the address the next byte would be written to. A byte taken while `perm_allow` is low is not written to RAM. Bytes at allowed offsets in the same page are still written.
- R7: `busy` rises in the cycle after the committing `cs_rise` and stays high for exactly `COMMIT_CYCLES` cycles.
- R8: `wel_clear` is high for exactly one cycle, the first cycle after a commit's `busy` falls, and at no other time.
- R9: While `busy` is high, `start_valid` is ignored (no collection opens, so `in_ready` is still low once busy ends), `in_ready` is low, and `rd_ok` is low. While not busy, `rd_ok` follows `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Pulse: a write's address phase has completed |
| start_addr | input | ADDR_W | Start address of the write |
| in_valid | input | 1 | A completed data byte is offered |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| in_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has risen (one-cycle event) |
| cs_on_boundary | input | 1 | The rise came right after bit 0 of a data byte |
| perm_addr | output | ADDR_W | Address the next byte would land on |
| perm_allow | input | 1 | The address on `perm_addr` may be written |
| rd_req | input | 1 | Array read command requested |
| rd_ok | output | 1 | Array read may proceed |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | ADDR_W | RAM write address |
| mem_wdata | output | 8 | RAM write data |
| busy | output | 1 | Write in progress |
| wel_clear | output | 1 | One-cycle pulse: clear the write enable latch |

## Verification
Faults in the offset pointer or the byte-valid mask show up at the RAM port within `PAGE_BYTES` cycles of the commit, as a write at the wrong offset, a missing write or an extra write. The bench scoreboard compares every RAM write, in order, against a page model built from the requirements. Faults in the commit decision show up one cycle after `cs_rise`, as `busy` rising when it should stay low or staying low when it should rise. Faults in the cycle counter show up when `busy` falls, as a busy period of the wrong length or a misplaced `wel_clear`. A write accepted during the busy period shows up as `in_ready` being high once the period ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_FILL = 1'b1
  } pwb_phase_e;
endpackage

// File: rtl/pwb_fill.sv
// Page buffer: byte storage, per-offset keep mask and the wrapping in-page pointer.
module pwb_fill #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              take,
  input  logic [7:0]        take_data,
  input  logic              take_allow,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
  output logic              any_byte,
  output logic [7:0]        rd_data,
  output logic              rd_mark
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic [7:0]            store_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] keep_q;
  logic [PG_W-1:0]       page_q;
  logic [OFF_W-1:0]      off_q;
  logic                  got_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= '0;
      page_q <= '0;
      off_q  <= '0;
      got_q  <= 1'b0;
    end else if (load) begin
      keep_q <= '0;
      page_q <= load_addr[ADDR_W-1:OFF_W];
      off_q  <= load_addr[OFF_W-1:0];
      got_q  <= 1'b0;
    end else if (take) begin
      keep_q[off_q] <= take_allow;
      off_q         <= off_q + 1'b1;
      got_q         <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !load) store_q[off_q] <= take_data;
  end

  assign cur_addr = {page_q, off_q};
  assign page     = page_q;
  assign any_byte = got_q;
  assign rd_data  = store_q[rd_idx];
  assign rd_mark  = keep_q[rd_idx];
endmodule

// File: rtl/pwb_drain.sv
// Scans every page offset once, one per cycle, after a kick.
module pwb_drain #(
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          kick,
  output logic                          active,
  output logic [$clog2(PAGE_BYTES)-1:0] idx
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(PAGE_BYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (kick) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == LAST) active <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_timer.sv
// Busy window of a fixed cycle count, with a done pulse when it ends.
module pwb_timer #(
  parameter int COMMIT_CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (kick && !busy) begin
        busy  <= 1'b1;
        cnt_q <= LOAD;
      end else if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit #(
  parameter int ADDR_W        = 13,
  parameter int PAGE_BYTES    = 32,
  parameter int COMMIT_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              cs_rise,
  input  logic              cs_on_boundary,
  output logic [ADDR_W-1:0] perm_addr,
  input  logic              perm_allow,
  input  logic              rd_req,
  output logic              rd_ok,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              wel_clear
);
  import pwb_pkg::*;

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  pwb_phase_e      phase_q;
  logic            load, take, commit;
  logic            any_byte, rd_mark, drain_on;
  logic [7:0]      rd_data;
  logic [OFF_W-1:0] drain_idx;
  logic [PG_W-1:0] page;

  assign load   = start_valid && !busy && !cs_rise;
  assign take   = in_valid && in_ready;
  assign commit = (phase_q == PH_FILL) && cs_rise && cs_on_boundary && any_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else if (phase_q == PH_FILL && cs_rise) begin
      phase_q <= PH_IDLE;
    end else if (load) begin
      phase_q <= PH_FILL;
    end
  end

  assign in_ready = (phase_q == PH_FILL) && !busy;
  assign rd_ok    = rd_req && !busy;

  pwb_fill #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_addr  (start_addr),
    .take       (take),
    .take_data  (in_data),
    .take_allow (perm_allow),
    .rd_idx     (drain_idx),
    .cur_addr   (perm_addr),
    .page       (page),
    .any_byte   (any_byte),
    .rd_data    (rd_data),
    .rd_mark    (rd_mark)
  );

  pwb_drain #(.PAGE_BYTES(PAGE_BYTES)) u_drain (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (commit),
    .active (drain_on),
    .idx    (drain_idx)
  );

  pwb_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (commit),
    .busy  (busy),
    .done  (wel_clear)
  );

  assign mem_we    = drain_on && rd_mark;
  assign mem_addr  = {page, drain_idx};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/pwb_commit_chk.sv
module pwb_commit_chk #(
  parameter int ADDR_W        = 13,
  parameter int PAGE_BYTES    = 32,
  parameter int COMMIT_CYCLES = 2000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic [ADDR_W-1:0] start_addr,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_data,
  input logic              cs_rise,
  input logic              cs_on_boundary,
  input logic [ADDR_W-1:0] perm_addr,
  input logic              perm_allow,
  input logic              rd_req,
  input logic              rd_ok,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              busy,
  input logic              wel_clear
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [31:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_write_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]) &&
       mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0])));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (busy_len == COMMIT_CYCLES));

  assert_wel_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |-> (!busy && $past(busy)));

  assert_wel_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |=> !wel_clear);

  assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!in_ready && !rd_ok));
endmodule

bind pwb_commit pwb_commit_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .COMMIT_CYCLES(COMMIT_CYCLES)
) u_chk (.*);

// File: tb/pwb_commit_test.sv
`timescale 1ns/1ps
module pwb_commit_test;
  localparam int AW = 13;
  localparam int PB = 32;
  localparam int CC = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic cs_rise = 1'b0;
  logic cs_on_boundary = 1'b0;
  logic [AW-1:0] perm_addr;
  logic perm_allow;
  logic rd_req = 1'b0;
  logic rd_ok;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic busy;
  logic wel_clear;

  logic [13:0] prot_from = 14'h2000;
  assign perm_allow = ({1'b0, perm_addr} < prot_from);

  always #2.5 clk = ~clk;

  pwb_commit #(.ADDR_W(AW), .PAGE_BYTES(PB), .COMMIT_CYCLES(CC)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
    .perm_addr(perm_addr), .perm_allow(perm_allow),
    .rd_req(rd_req), .rd_ok(rd_ok),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel_clear(wel_clear)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [AW+7:0] exp_q[$];
  logic [7:0] mdl [PB];
  bit mkeep [PB];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every RAM write must match the head of the scoreboard queue (R5, R6, R3).
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected RAM write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [AW+7:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R5 RAM write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic send_op(input logic [AW-1:0] a, input int n, input logic [7:0] seed, input bit bnd);
    @(posedge clk); #1;
    start_valid = 1'b1; start_addr = a;
    @(posedge clk); #1;
    start_valid = 1'b0;
    for (int k = 0; k < PB; k++) mkeep[k] = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [4:0] off;
      off = 5'(a[4:0] + i);
      in_valid = 1'b1;
      in_data = 8'(seed + i);
      mdl[off] = in_data;
      mkeep[off] = ({1'b0, a[12:5], off} < prot_from);
      @(negedge clk);
      chk(in_ready, "R2 in_ready during collection", in_ready, 1);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    cs_rise = 1'b1;
    cs_on_boundary = bnd;
    if (bnd && n > 0)
      for (int k = 0; k < PB; k++)
        if (mkeep[k]) exp_q.push_back({a[12:5], 5'(k), mdl[k]});
    @(posedge clk); #1;
    cs_rise = 1'b0;
    cs_on_boundary = 1'b0;
  endtask

  task automatic finish_op(input bit expect_commit, input bit probe);
    if (expect_commit) begin
      int cnt = 0;
      forever begin
        @(negedge clk);
        if (!busy) break;
        cnt++;
        if (probe && cnt == 10) begin
          start_valid = 1'b1; start_addr = 13'h0040; rd_req = 1'b1; in_valid = 1'b1;
        end
        if (probe && cnt == 11) begin
          chk(!rd_ok, "R9 rd_ok low while busy", rd_ok, 0);
          chk(!in_ready, "R9 in_ready low while busy", in_ready, 0);
          start_valid = 1'b0; rd_req = 1'b0; in_valid = 1'b0;
        end
      end
      chk(cnt == CC, "R7 busy length", cnt, CC);
      chk(wel_clear, "R8 wel_clear after busy", wel_clear, 1);
      chk(exp_q.size() == 0, "R5 all writes done", exp_q.size(), 0);
      @(negedge clk);
      chk(!wel_clear, "R8 wel_clear single cycle", wel_clear, 0);
      chk(!in_ready, "R9 start during busy ignored", in_ready, 0);
    end else begin
      bit bad = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (busy || wel_clear) bad = 1'b1;
      end
      chk(!bad, "R4 discarded write: no busy/wel_clear", bad, 0);
      chk(exp_q.size() == 0, "R4 discarded write: queue empty", exp_q.size(), 0);
      chk(!in_ready, "R4 collection closed", in_ready, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !in_ready && !mem_we && !wel_clear, "R1 reset state",
        {busy, in_ready, mem_we, wel_clear}, 0);
    rd_req = 1'b1;
    @(negedge clk);
    chk(rd_ok, "R9 rd_ok follows rd_req when idle", rd_ok, 1);
    rd_req = 1'b0;

    // R4/R5/R7/R8: single byte, clean rise, with busy probe for R9
    send_op(13'h0123, 1, 8'hA5, 1'b1);
    finish_op(1'b1, 1'b1);

    // R3: wrap from offset 30
    send_op(13'h045E, 5, 8'h10, 1'b1);
    finish_op(1'b1, 1'b0);

    // R3: 40 bytes overwrite earlier ones
    send_op(13'h0A04, 40, 8'h60, 1'b1);
    finish_op(1'b1, 1'b0);

    // R4: rise off a byte boundary discards
    send_op(13'h0200, 3, 8'h33, 1'b0);
    finish_op(1'b0, 1'b0);

    // R4: clean rise with no data byte discards
    send_op(13'h0300, 0, 8'h00, 1'b1);
    finish_op(1'b0, 1'b0);

    // R6: upper half of page protected
    prot_from = 14'h1810;
    send_op(13'h1800, 32, 8'hC0, 1'b1);
    finish_op(1'b1, 1'b0);
    prot_from = 14'h2000;

    // R2: buffer reusable after a protected commit
    send_op(13'h1FFF, 2, 8'h77, 1'b1);
    finish_op(1'b1, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule